// File: doc/BRIEF.md
# Dual 32-bit Interval Timer with Compare Event

This peripheral holds two independent up-counters, a low half and a high half, behind a small 32-bit register bus. Each half has its own period register and a 2-bit run-mode field in a shared control register. A half can be off, run once up to its period, or run in a loop that reloads from zero. When a half matches its period, it pulses its own interrupt line for one clock.

A global control register releases each half from reset and selects the timer mode. Only the dual, unchained mode is built. In any other mode both counters stand still.

A compare register on the low half lets that counter serve as a free-running time base and also as an event source. Software reads the low count, adds a delta and writes the sum to the compare register. An event pulse then fires when the counter advances onto that value. The sum wraps modulo 2^32, and deltas from 1 to 0xFFFFFFFE are usable. Register offsets are byte addresses on a 6-bit address bus:

| Offset | Register |
|---|---|
| 0x10 | low count |
| 0x14 | high count |
| 0x18 | low period |
| 0x1C | high period |
| 0x20 | run-mode control |
| 0x24 | global control |
| 0x28 | compare |

Writes take effect at the clock edge where `bus_we` is high. `bus_rdata` is a combinational view of the addressed register.

Top module: `twin_timer`

## Requirements
- R1: After reset every register reads 0 and `irq_lo`, `irq_hi` and `irq_cmp` are low.
- R2: Count, period and compare registers read back all 32 bits as written. Run-mode control keeps only bits [7:6] (low half) and [23:22] (high half). Global control keeps only bits [3:0]. Unused bits and unmapped offsets read as 0.
- R3: A half advances by one per clock only when all of these hold: its release bit in global control is 1 (bit 0 for the low half, bit 1 for the high half); global control bits [3:2] equal 01; its run-mode field is 01 or 10. Otherwise it holds its value and raises no interrupt. Run-mode value 11 acts as off.
- R4: In loop mode (field 10), a count equal to the period goes to 0 on the next edge and the half's interrupt is high for exactly that one following cycle. With period P, the interrupt therefore comes every P+1 clocks.
- R5: In one-shot mode (field 01), a count equal to the period stays at that value, the interrupt pulses for one cycle and the hardware clears the run-mode field to 00.
- R6: A software write to a count register wins over counting in the same cycle. The written value appears after that edge and counting resumes from it.
- R7: No compare event occurs before the compare register is first written. Afterwards `irq_cmp` is high for the one cycle that follows the edge where the low counter advances to the compare value, and the low counter keeps running.
- R8: Writing 0 to the run-mode control register stops both halves, and their counts then stay constant.
- R9: Compare matching uses 32-bit modulo arithmetic. A target of count+delta that wraps past 0xFFFFFFFF fires after the counter wraps, and a delta of 1 fires on the next advance.
- R10: The high half counts, matches and interrupts independently of the low half, using its own count, period and field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | register write strobe |
| bus_addr | input | 6 | register byte offset |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data for `bus_addr` |
| irq_lo | output | 1 | low half period-match pulse |
| irq_hi | output | 1 | high half period-match pulse |
| irq_cmp | output | 1 | low counter compare-match pulse |

## Verification
The following properties are checked on every clock:
- An idle or non-dual half leaves its count unchanged.
- A period interrupt only follows a cycle in which that half was gated on and sat at its period.
- A one-shot completion freezes the count and clears the field.
- A compare event only follows an armed compare and an advancing counter.

Other behaviour can only be shown by the bench scenarios:
- the exact loop cadence of P+1;
- the counter values around a wrap;
- the cycle where a compare event lands for a wrapped target;
- write-over-count priority;
- the independence of the two halves.

// File: rtl/twt_pkg.sv
package twt_pkg;

  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 6'h10;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h14;
  localparam logic [ADDR_W-1:0] A_PRD_LO = 6'h18;
  localparam logic [ADDR_W-1:0] A_PRD_HI = 6'h1C;
  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h20;
  localparam logic [ADDR_W-1:0] A_GCTRL  = 6'h24;
  localparam logic [ADDR_W-1:0] A_CMP    = 6'h28;

  // run-mode field of one half
  typedef enum logic [1:0] {
    RUN_OFF  = 2'b00,
    RUN_ONCE = 2'b01,
    RUN_LOOP = 2'b10,
    RUN_RSVD = 2'b11
  } run_mode_e;

  // global timer-mode value for two unchained halves
  localparam logic [1:0] TMODE_DUAL = 2'b01;

endpackage

// File: rtl/twt_half.sv
module twt_half import twt_pkg::*; #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_i,
  input  run_mode_e     mode_i,
  input  logic          cnt_we_i,
  input  logic          prd_we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] prd_o,
  output logic          adv_o,
  output logic [DW-1:0] cnt_nxt_o,
  output logic          once_done_o,
  output logic          irq_o
);

  logic [DW-1:0] cnt_q, cnt_d, prd_q;
  logic          active, at_prd, cnt_en, irq_d, irq_q, adv;

  always_comb begin
    active = gate_i && ((mode_i == RUN_ONCE) || (mode_i == RUN_LOOP));
    at_prd = (cnt_q == prd_q);
    cnt_d  = cnt_q;
    irq_d  = 1'b0;
    adv    = 1'b0;
    if (cnt_we_i) begin
      cnt_d = wdata_i;
    end else if (active) begin
      if (at_prd) begin
        irq_d = 1'b1;
        if (mode_i == RUN_LOOP) begin
          cnt_d = '0;
          adv   = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
        adv   = 1'b1;
      end
    end
    cnt_en = cnt_we_i || active;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      prd_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (cnt_en)   cnt_q <= cnt_d;
      if (prd_we_i) prd_q <= wdata_i;
      irq_q <= irq_d;
    end
  end

  assign cnt_o       = cnt_q;
  assign prd_o       = prd_q;
  assign adv_o       = adv;
  assign cnt_nxt_o   = cnt_d;
  assign once_done_o = irq_d && (mode_i == RUN_ONCE);
  assign irq_o       = irq_q;

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_i && !cnt_we_i) |=> $stable(cnt_o));

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(gate_i && !cnt_we_i && (cnt_o == prd_o)));

  // R5
  once_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    once_done_o |=> $stable(cnt_o));

endmodule

// File: rtl/twt_cmp.sv
module twt_cmp #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          adv_i,
  input  logic [DW-1:0] cnt_nxt_i,
  output logic [DW-1:0] cmp_o,
  output logic          irq_o
);

  logic [DW-1:0] cmp_q;
  logic          armed_q, irq_d, irq_q;

  always_comb begin
    irq_d = armed_q && adv_i && (cnt_nxt_i == cmp_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (cmp_we_i) begin
        cmp_q   <= wdata_i;
        armed_q <= 1'b1;
      end
      irq_q <= irq_d;
    end
  end

  assign cmp_o = cmp_q;
  assign irq_o = irq_q;

  // R7
  cmp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(armed_q && adv_i));

endmodule

// File: rtl/twin_timer.sv
module twin_timer import twt_pkg::*; #(
  parameter int unsigned DW           = 32,
  parameter int unsigned LO_FIELD_LSB = 6,
  parameter int unsigned HI_FIELD_LSB = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              irq_cmp
);

  localparam int unsigned NH = 2;
  localparam int unsigned FLSB [NH] = '{LO_FIELD_LSB, HI_FIELD_LSB};

  // reset: asserted at once, released after two clocks
  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  logic [NH-1:0] cnt_we, prd_we, gate, done, irq, adv;
  logic          ctrl_we, gctrl_we, cmp_we;
  logic [NH-1:0] rel_q, rel_d;
  logic [1:0]    tmode_q, tmode_d;
  run_mode_e     mode_q [NH];
  run_mode_e     mode_d [NH];
  logic [DW-1:0] cnt [NH];
  logic [DW-1:0] prd [NH];
  logic [DW-1:0] nxt [NH];
  logic [DW-1:0] cmp_val;

  always_comb begin
    ctrl_we   = bus_we && (bus_addr == A_CTRL);
    gctrl_we  = bus_we && (bus_addr == A_GCTRL);
    cmp_we    = bus_we && (bus_addr == A_CMP);
    cnt_we[0] = bus_we && (bus_addr == A_CNT_LO);
    cnt_we[1] = bus_we && (bus_addr == A_CNT_HI);
    prd_we[0] = bus_we && (bus_addr == A_PRD_LO);
    prd_we[1] = bus_we && (bus_addr == A_PRD_HI);
    rel_d     = bus_wdata[NH-1:0];
    tmode_d   = bus_wdata[3:2];
    for (int i = 0; i < NH; i++) begin
      gate[i]   = rel_q[i] && (tmode_q == TMODE_DUAL);
      mode_d[i] = mode_q[i];
      if (ctrl_we)      mode_d[i] = run_mode_e'(bus_wdata[FLSB[i] +: 2]);
      else if (done[i]) mode_d[i] = RUN_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rel_q   <= '0;
      tmode_q <= '0;
      for (int i = 0; i < NH; i++) mode_q[i] <= RUN_OFF;
    end else begin
      if (gctrl_we) begin
        rel_q   <= rel_d;
        tmode_q <= tmode_d;
      end
      for (int i = 0; i < NH; i++) begin
        if (ctrl_we || done[i]) mode_q[i] <= mode_d[i];
      end
    end
  end

  for (genvar g = 0; g < NH; g++) begin : g_half
    twt_half #(.DW(DW)) u_half (
      .clk         (clk),
      .rst_n       (rst_ns),
      .gate_i      (gate[g]),
      .mode_i      (mode_q[g]),
      .cnt_we_i    (cnt_we[g]),
      .prd_we_i    (prd_we[g]),
      .wdata_i     (bus_wdata),
      .cnt_o       (cnt[g]),
      .prd_o       (prd[g]),
      .adv_o       (adv[g]),
      .cnt_nxt_o   (nxt[g]),
      .once_done_o (done[g]),
      .irq_o       (irq[g])
    );
  end

  twt_cmp #(.DW(DW)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_ns),
    .cmp_we_i  (cmp_we),
    .wdata_i   (bus_wdata),
    .adv_i     (adv[0]),
    .cnt_nxt_i (nxt[0]),
    .cmp_o     (cmp_val),
    .irq_o     (irq_cmp)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[0];
      A_CNT_HI: bus_rdata = cnt[1];
      A_PRD_LO: bus_rdata = prd[0];
      A_PRD_HI: bus_rdata = prd[1];
      A_CMP:    bus_rdata = cmp_val;
      A_GCTRL:  bus_rdata[3:0] = {tmode_q, rel_q};
      A_CTRL: begin
        bus_rdata[LO_FIELD_LSB +: 2] = mode_q[0];
        bus_rdata[HI_FIELD_LSB +: 2] = mode_q[1];
      end
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_lo = irq[0];
  assign irq_hi = irq[1];

  // R3
  nondual_hold_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    ((tmode_q != TMODE_DUAL) && (cnt_we == '0)) |=> ($stable(cnt[0]) && $stable(cnt[1])));

  // R5
  once_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (done[0] && !ctrl_we) |=> (mode_q[0] == RUN_OFF));

  // R10
  hi_gate_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    adv[1] |-> (rel_q[1] && (tmode_q == TMODE_DUAL)));

endmodule

// File: tb/twin_timer_tb_top.sv
`timescale 1ns/10ps
module twin_timer_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi, irq_cmp;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  twin_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
  );

  localparam logic [5:0] CL = 6'h10, CH = 6'h14, PL = 6'h18, PH = 6'h1C;
  localparam logic [5:0] CT = 6'h20, GC = 6'h24, CM = 6'h28;

  // {addr, write data, expected read-back}; R2 masking
  localparam logic [69:0] VEC [12] = '{
    {PL,   32'hDEADBEEF, 32'hDEADBEEF},
    {PH,   32'h12345678, 32'h12345678},
    {CT,   32'hFFFFFFFF, 32'h00C000C0},
    {GC,   32'hFFFFFFFF, 32'h0000000F},
    {CL,   32'h00000005, 32'h00000005},
    {CH,   32'h00000009, 32'h00000009},
    {6'h2C,32'hFFFFFFFF, 32'h00000000},
    {6'h00,32'hFFFFFFFF, 32'h00000000},
    {GC,   32'h00000000, 32'h00000000},
    {CT,   32'h00000000, 32'h00000000},
    {CL,   32'h00000000, 32'h00000000},
    {CH,   32'h00000000, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.2;
    d = bus_rdata;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d, a0, tgt;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    foreach (VEC[k]) begin
      rd(VEC[k][69:64], d); chk("R1", d, 32'h0);
    end
    rd(CM, d); chk("R1", d, 32'h0);
    chk("R1", {29'h0, irq_lo, irq_hi, irq_cmp}, 32'h0);

    // R2 register table
    foreach (VEC[k]) begin
      wr(VEC[k][69:64], VEC[k][63:32]);
      rd(VEC[k][69:64], d);
      chk("R2", d, VEC[k][31:0]);
    end

    // R4 loop mode, period 3; R7 no compare before arming
    wr(PL, 32'd3); wr(GC, 32'h7); wr(CT, 32'h80);
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk);
      rd(CL, d); chk("R4 count", d, i % 4);
      chk("R4 irq", {31'h0, irq_lo}, {31'h0, (i % 4) == 0});
      chk("R7 unarmed", {31'h0, irq_cmp}, 32'h0);
    end

    // R8 stop both
    wr(CT, 32'h0); rd(CL, a0);
    repeat (5) @(negedge clk);
    rd(CL, d); chk("R8", d, a0);
    chk("R8 irq", {31'h0, irq_lo}, 32'h0);

    // R5 one-shot, period 2
    wr(CL, 32'h0); wr(PL, 32'd2); wr(CT, 32'h40);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      rd(CL, d); chk("R5 count", d, (i < 2) ? i : 2);
      chk("R5 irq", {31'h0, irq_lo}, {31'h0, i == 3});
    end
    rd(CT, d); chk("R5 field cleared", d, 32'h0);

    // R6 write wins over counting
    wr(PL, 32'hFFFFFFFF); wr(CT, 32'h80);
    repeat (3) @(negedge clk);
    wr(CL, 32'h100); rd(CL, d); chk("R6", d, 32'h100);
    @(negedge clk); rd(CL, d); chk("R6 resume", d, 32'h101);

    // R3 gating
    wr(GC, 32'h6); rd(CL, a0);
    repeat (3) @(negedge clk); rd(CL, d); chk("R3 release bit", d, a0);
    wr(GC, 32'h3); rd(CL, a0);
    repeat (3) @(negedge clk); rd(CL, d); chk("R3 tmode", d, a0);
    wr(GC, 32'h7); wr(CT, 32'hC0); rd(CL, a0);
    repeat (3) @(negedge clk); rd(CL, d); chk("R3 mode 11", d, a0);
    wr(CT, 32'h80); rd(CL, a0);
    @(negedge clk); rd(CL, d); chk("R3 resume", d, a0 + 1);

    // R10 high half alone, period 5
    wr(CT, 32'h0); wr(CH, 32'h0); wr(PH, 32'd5); rd(CL, a0);
    wr(CT, 32'h00800000);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      rd(CH, d); chk("R10 count", d, i % 6);
      chk("R10 irq", {31'h0, irq_hi}, {31'h0, (i % 6) == 0});
      chk("R10 lo quiet", {31'h0, irq_lo}, 32'h0);
    end
    rd(CL, d); chk("R10 lo held", d, a0);

    // R7 compare at 7
    wr(CT, 32'h0); wr(CL, 32'h0); wr(CM, 32'd7);
    rd(CM, d); chk("R2 cmp", d, 32'd7);
    wr(CT, 32'h80);
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      rd(CL, d); chk("R7 count", d, i);
      chk("R7 irq", {31'h0, irq_cmp}, {31'h0, i == 7});
    end

    // R9 wrapped target
    wr(CT, 32'h0); wr(CL, 32'hFFFFFFFE);
    tgt = 32'hFFFFFFFE + 32'd3;
    wr(CM, tgt); wr(CT, 32'h80);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      rd(CL, d); chk("R9 count", d, 32'hFFFFFFFE + i);
      chk("R9 irq", {31'h0, irq_cmp}, {31'h0, i == 3});
    end

    // R9 delta of 1
    wr(CT, 32'h0); rd(CL, a0);
    wr(CM, a0 + 1); wr(CT, 32'h80);
    @(negedge clk);
    rd(CL, d); chk("R9 delta1 count", d, a0 + 1);
    chk("R9 delta1 irq", {31'h0, irq_cmp}, 32'h1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule